// File: doc/BRIEF.md
# Flash Command Register Controller

This block is the command-register state machine in front of a byte-wide nonvolatile array. A host writes command bytes over an asynchronous-style bus: chip-enable, write-enable and output-enable, all active low, sampled on the block clock. The controller decodes those writes and runs program and erase operations, each started by a two-write sequence. It holds every program or erase pulse until a verify or reset command arrives, or until an internal stop timer ends it. A programming-voltage flag gates every alteration. Without it the block behaves as a plain read-only memory.

Reads return one of three sources, chosen by the last command: array data at the bus address, identifier bytes, or verify data taken from the address latched by the operation. The array is held in the block as a block-RAM-style memory. Erase sweeps it one byte per clock while the erase pulse lasts.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `vpp_hi` is low every write is ignored and the controller is held in read-array mode, so reads return array data at the bus address.
- R2: A write is taken only in the first clock in which `ce_n` and `we_n` are both low. The address and data sampled in that clock are used. With either line high no command is taken.
- R3: Writing 40h and then a second write programs the byte given by that second write at that second write's address. After C0h, reads return the byte stored at that latched address.
- R4: Alteration needs two steps. Erase starts only on 20h followed by 20h. Any other second byte returns the controller to read mode with the array unchanged. A program pulse can only follow a 40h write.
- R5: `pulse_active` is high while a program or erase pulse runs. Any command write accepted during the pulse ends it and is decoded as a new command.
- R6: A program pulse lasts at most PGM_TICKS clocks and an erase pulse at most ERS_TICKS clocks. When the limit is reached, `pulse_active` falls and the controller enters a halted state. In that state it leaves only on A0h, C0h or FFh and ignores every other byte, while reads return array data.
- R7: Reset (synchronous, active high) returns the controller to read-array mode with `rdata` = 00h, `rdata_oe` = 0 and `pulse_active` = 0. It discards any half-entered sequence.
- R8: The erase pulse writes FFh to every address in turn, from address 0 upward, one per clock. A0h latches its write address, and reads then return the byte at that address.
- R9: After 90h, reads return MFR_CODE at address 0, DEV_CODE at address 1 and 00h at every other address.
- R10: `rdata_oe` is high, and `rdata` carries data, two clocks after a clock in which `ce_n` and `oe_n` are both low. Otherwise `rdata` is 00h.
- R11: 00h selects read-array mode. FFh followed by any write returns to read mode. Any byte that is not a command code selects read-array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data / command byte |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming voltage present |
| rdata | output | 8 | Registered read data |
| rdata_oe | output | 1 | Read data valid / drive enable |
| pulse_active | output | 1 | Program or erase pulse in progress |

## Verification
The bench builds the block with ADDR_W = 5, PGM_TICKS = 8 and ERS_TICKS = 48. With a 32-byte array, a full erase sweep completes well inside one erase pulse. Both stop-timer expiries can be reached within a few dozen clocks, and random addresses land on programmed bytes often. The identifier boundary at addresses 0 and 1, and the halted-state filter on command bytes, are driven directly.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_IDENT, ST_ERS_ARM, ST_ERS_RUN, ST_ERS_CHK,
    ST_PGM_ARM, ST_PGM_RUN, ST_PGM_CHK, ST_RST_ARM, ST_HALT
  } fcr_state_e;

  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_ERS_CHK = 8'hA0;
  localparam logic [7:0] OP_PGM     = 8'h40;
  localparam logic [7:0] OP_PGM_CHK = 8'hC0;
  localparam logic [7:0] OP_RESET   = 8'hFF;

  // Mode entered by a first-step command byte; unknown bytes fall back to read.
  function automatic fcr_state_e decode_op(input logic [7:0] op);
    case (op)
      OP_IDENT:   decode_op = ST_IDENT;
      OP_ERASE:   decode_op = ST_ERS_ARM;
      OP_ERS_CHK: decode_op = ST_ERS_CHK;
      OP_PGM:     decode_op = ST_PGM_ARM;
      OP_PGM_CHK: decode_op = ST_PGM_CHK;
      OP_RESET:   decode_op = ST_RST_ARM;
      default:    decode_op = ST_READ;
    endcase
  endfunction

endpackage

// File: rtl/fcr_bus_strobe.sv
module fcr_bus_strobe (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic we_n,
  output logic stb
);
  logic act, act_q;

  assign act = !ce_n && !we_n;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= act;
  end

  // One-clock pulse on the first clock of a write cycle.
  assign stb = act && !act_q;
endmodule

// File: rtl/fcr_stop_timer.sv
module fcr_stop_timer #(
  parameter int PGM_TICKS = 1000,
  parameter int ERS_TICKS = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic sel_erase,
  input  logic run,
  output logic expired
);
  localparam int MAX_TICKS = (ERS_TICKS > PGM_TICKS) ? ERS_TICKS : PGM_TICKS;
  localparam int TW        = $clog2(MAX_TICKS + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (load)                 cnt_q <= sel_erase ? TW'(ERS_TICKS - 1) : TW'(PGM_TICKS - 1);
    else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = run && (cnt_q == '0);
endmodule

// File: rtl/fcr_array.sv
module fcr_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcr_pkg::*;
#(
  parameter int         ADDR_W    = 10,
  parameter int         PGM_TICKS = 1000,
  parameter int         ERS_TICKS = 100000,
  parameter logic [7:0] MFR_CODE  = 8'h5A,
  parameter logic [7:0] DEV_CODE  = 8'hC3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  output logic [7:0]        rdata,
  output logic              rdata_oe,
  output logic              pulse_active
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  fcr_state_e        state_q, state_d;
  logic              wr_stb, run_now;
  logic [ADDR_W-1:0] lat_addr_q, sweep_q;
  logic [7:0]        lat_data_q;
  logic              sweep_done_q;
  logic              tmr_load, tmr_erase, tmr_expired;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_waddr, arr_raddr;
  logic [7:0]        arr_wdata, arr_q;
  logic              oe_p1_q, id_sel_q;
  logic [7:0]        id_byte_q;

  fcr_bus_strobe u_stb (.clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .stb(wr_stb));

  assign run_now = (state_q == ST_PGM_RUN) || (state_q == ST_ERS_RUN);

  always_comb begin
    state_d = state_q;
    if (!vpp_hi) begin
      state_d = ST_READ;
    end else begin
      case (state_q)
        ST_HALT: begin
          if (wr_stb && (bus_wdata == OP_ERS_CHK || bus_wdata == OP_PGM_CHK ||
                         bus_wdata == OP_RESET))
            state_d = decode_op(bus_wdata);
        end
        ST_PGM_RUN, ST_ERS_RUN: begin
          if (wr_stb)           state_d = decode_op(bus_wdata);
          else if (tmr_expired) state_d = ST_HALT;
        end
        ST_ERS_ARM: if (wr_stb) state_d = (bus_wdata == OP_ERASE) ? ST_ERS_RUN : ST_READ;
        ST_PGM_ARM: if (wr_stb) state_d = ST_PGM_RUN;
        ST_RST_ARM: if (wr_stb) state_d = ST_READ;
        default:    if (wr_stb) state_d = decode_op(bus_wdata);
      endcase
    end
  end

  assign tmr_erase = (state_d == ST_ERS_RUN);
  assign tmr_load  = ((state_d == ST_ERS_RUN) || (state_d == ST_PGM_RUN)) && !run_now;

  fcr_stop_timer #(.PGM_TICKS(PGM_TICKS), .ERS_TICKS(ERS_TICKS)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .sel_erase(tmr_erase),
    .run(run_now), .expired(tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_READ;
      lat_addr_q   <= '0;
      lat_data_q   <= '0;
      sweep_q      <= '0;
      sweep_done_q <= 1'b1;
    end else begin
      state_q <= state_d;
      if (wr_stb && vpp_hi && state_q == ST_PGM_ARM) begin
        lat_addr_q <= bus_addr;
        lat_data_q <= bus_wdata;
      end else if (wr_stb && vpp_hi && state_d == ST_ERS_CHK) begin
        lat_addr_q <= bus_addr;
      end
      if (tmr_load && tmr_erase) begin
        sweep_q      <= '0;
        sweep_done_q <= 1'b0;
      end else if (state_q == ST_ERS_RUN && !sweep_done_q) begin
        if (sweep_q == LAST_ADDR) sweep_done_q <= 1'b1;
        else                      sweep_q      <= sweep_q + 1'b1;
      end
    end
  end

  // Array access: erase sweeps FFh, program rewrites the latched byte each pulse clock.
  assign arr_we    = (state_q == ST_PGM_RUN) || (state_q == ST_ERS_RUN && !sweep_done_q);
  assign arr_waddr = (state_q == ST_ERS_RUN) ? sweep_q : lat_addr_q;
  assign arr_wdata = (state_q == ST_ERS_RUN) ? 8'hFF : lat_data_q;
  assign arr_raddr = (state_q == ST_ERS_CHK || state_q == ST_PGM_CHK) ? lat_addr_q : bus_addr;

  fcr_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(arr_raddr), .rdata(arr_q)
  );

  // Two-stage read path aligned with the registered memory output.
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_p1_q   <= 1'b0;
      id_sel_q  <= 1'b0;
      id_byte_q <= '0;
      rdata     <= '0;
      rdata_oe  <= 1'b0;
    end else begin
      oe_p1_q  <= !ce_n && !oe_n;
      id_sel_q <= (state_q == ST_IDENT);
      if (bus_addr == '0)                   id_byte_q <= MFR_CODE;
      else if (bus_addr == ADDR_W'(1))      id_byte_q <= DEV_CODE;
      else                                  id_byte_q <= 8'h00;
      rdata    <= oe_p1_q ? (id_sel_q ? id_byte_q : arr_q) : 8'h00;
      rdata_oe <= oe_p1_q;
    end
  end

  assign pulse_active = run_now;

  AST_VPP_LOW_READ: assert property (@(posedge clk) disable iff (rst)
    !vpp_hi |=> state_q == ST_READ); // R1
  AST_WRITE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    (state_q != $past(state_q) && $past(state_q) != ST_PGM_RUN &&
     $past(state_q) != ST_ERS_RUN && $past(vpp_hi)) |-> $past(!ce_n && !we_n)); // R2
  AST_PGM_AFTER_ARM: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PGM_RUN && $past(state_q) != ST_PGM_RUN) |-> $past(state_q) == ST_PGM_ARM); // R4
  AST_ERS_AFTER_ARM: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ERS_RUN && $past(state_q) != ST_ERS_RUN) |-> $past(state_q) == ST_ERS_ARM); // R4
  AST_HALT_AFTER_TIMER: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HALT && $past(state_q) != ST_HALT) |-> $past(tmr_expired)); // R6
  AST_HALT_EXIT_CODES: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == ST_HALT && state_q != ST_HALT && $past(vpp_hi)) |->
    ($past(bus_wdata) == OP_ERS_CHK || $past(bus_wdata) == OP_PGM_CHK ||
     $past(bus_wdata) == OP_RESET)); // R6
  AST_RESET_READ: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> state_q == ST_READ); // R7
  AST_OE_GATE: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> $past(!ce_n && !oe_n, 2)); // R10
endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;
  localparam int PGM_T = 8;
  localparam int ERS_T = 48;
  localparam logic [7:0] MFR = 8'h5A;
  localparam logic [7:0] DEV = 8'hC3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b1;
  logic [7:0] rdata;
  logic rdata_oe, pulse_active;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .PGM_TICKS(PGM_T), .ERS_TICKS(ERS_T),
                   .MFR_CODE(MFR), .DEV_CODE(DEV)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .rdata(rdata), .rdata_oe(rdata_oe), .pulse_active(pulse_active));

  logic [7:0] model [DEPTH];
  int checks = 0;
  int fails = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_id(input logic [AW-1:0] a);
    if (a == 0) return MFR;
    if (a == 1) return DEV;
    return 8'h00;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    d = rdata;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic full_erase();
    wr(0, 8'h20); wr(0, 8'h20);
    chk("R5 erase pulse active", {7'b0, pulse_active}, 8'h01);
    idle(ERS_T + 6);
    chk("R6 erase pulse timed out", {7'b0, pulse_active}, 8'h00);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
  endtask

  task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d, input bit timeout);
    logic [7:0] v;
    wr(0, 8'h40); wr(a, d);
    chk("R5 program pulse active", {7'b0, pulse_active}, 8'h01);
    if (timeout) begin
      idle(PGM_T + 4);
      chk("R6 program pulse timed out", {7'b0, pulse_active}, 8'h00);
    end
    wr(0, 8'hC0);
    chk("R5 verify ends pulse", {7'b0, pulse_active}, 8'h00);
    model[a] = d;
    rd(a ^ 5'h1F, v);
    chk("R3 program verify data", v, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4711));
    idle(4);
    rst = 1'b0;
    idle(1);
    chk("R7 reset rdata", rdata, 8'h00);
    chk("R7 reset rdata_oe", {7'b0, rdata_oe}, 8'h00);
    chk("R7 reset pulse_active", {7'b0, pulse_active}, 8'h00);

    // R8: full erase, then erase verify at a latched address
    full_erase();
    wr(7, 8'hA0);
    rd(3, v); chk("R8 erase verify FFh", v, 8'hFF);
    wr(0, 8'hFF); wr(0, 8'hFF);
    rd(9, v); chk("R11 FF FF back to read", v, 8'hFF);

    // R3 program via verify command
    program_byte(0, 8'h11, 1'b0);
    program_byte(1, 8'h22, 1'b0);
    program_byte(4, 8'h3C, 1'b0);
    wr(0, 8'h00);
    rd(4, v); chk("R3 read back in array mode", v, 8'h3C);

    // R6: halted state ignores 90h, reads array, exits on C0h
    wr(0, 8'h40); wr(12, 8'h77); model[12] = 8'h77;
    idle(PGM_T + 4);
    chk("R6 pulse dropped", {7'b0, pulse_active}, 8'h00);
    wr(0, 8'h90);
    rd(0, v); chk("R6 halt ignores 90h", v, model[0]);
    wr(0, 8'hC0);
    rd(0, v); chk("R6 exit halt via C0h", v, 8'h77);

    // R9 identifier
    wr(0, 8'h90);
    rd(0, v); chk("R9 manufacturer code", v, MFR);
    rd(1, v); chk("R9 device code", v, DEV);
    rd(5, v); chk("R9 other address", v, 8'h00);
    wr(0, 8'h00);
    rd(1, v); chk("R11 00h read array", v, model[1]);

    // R1 no programming voltage
    vpp_hi = 1'b0;
    wr(0, 8'h40); wr(4, 8'h00);
    wr(0, 8'h90);
    vpp_hi = 1'b1;
    rd(4, v); chk("R1 program ignored", v, model[4]);
    rd(0, v); chk("R1 identifier ignored", v, model[0]);

    // R2 write blocked with CE high
    @(negedge clk); bus_wdata = 8'h90; ce_n = 1'b1; we_n = 1'b0;
    idle(2); we_n = 1'b1; idle(1);
    rd(0, v); chk("R2 CE high blocks write", v, model[0]);

    // R4 aborted two-step sequences
    wr(0, 8'h20); wr(0, 8'h00);
    chk("R4 no erase pulse", {7'b0, pulse_active}, 8'h00);
    rd(4, v); chk("R4 erase abort keeps data", v, model[4]);
    wr(0, 8'h20); wr(0, 8'h90);
    rd(0, v); chk("R4 abort goes to read", v, model[0]);

    // R11 unknown code and FF FF from identifier mode
    wr(0, 8'h90); wr(0, 8'h55);
    rd(0, v); chk("R11 unknown code read mode", v, model[0]);
    wr(0, 8'h90); wr(0, 8'hFF); wr(0, 8'hFF);
    rd(1, v); chk("R11 reset sequence", v, model[1]);

    // R7 reset discards half-entered program
    wr(0, 8'h40);
    @(negedge clk); rst = 1'b1; idle(2); rst = 1'b0;
    wr(6, 8'h90);
    rd(0, v); chk("R7 second write decoded as command", v, MFR);
    wr(0, 8'h00);
    rd(6, v); chk("R7 array unchanged after reset", v, model[6]);

    // R10 output gating
    @(negedge clk); bus_addr = 4; ce_n = 1'b0; oe_n = 1'b1;
    idle(3);
    chk("R10 oe high no drive", {7'b0, rdata_oe}, 8'h00);
    chk("R10 oe high rdata zero", rdata, 8'h00);
    ce_n = 1'b1;
    @(negedge clk); oe_n = 1'b0;
    idle(3);
    chk("R10 ce high rdata zero", rdata, 8'h00);
    oe_n = 1'b1;

    // Random mix
    for (int it = 0; it < 60; it++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      int op;
      a = AW'($urandom);
      d = 8'($urandom);
      op = $urandom % 3;
      if (op == 0) begin
        program_byte(a, d, ($urandom % 4) == 0);
        wr(0, 8'h00);
      end else if (op == 1) begin
        rd(a, v); chk("R3 random array read", v, model[a]);
      end else begin
        wr(0, 8'h90);
        rd(a, v); chk("R9 random identifier read", v, exp_id(a));
        wr(0, 8'h00);
      end
    end

    // R8 final erase covers every byte
    full_erase();
    wr(0, 8'h00);
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      rd(a, v); chk("R8 erased byte", v, 8'hFF);
    end
    rd(AW'(DEPTH - 1), v); chk("R8 last address erased", v, 8'hFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule